// File: doc/BRIEF.md
# Configuration Memory Parser with String Table Lookup

This block sits behind a byte-wide read port to a 256-byte serial configuration memory. The transport that actually moves bits (two-wire or four-wire serial) lives elsewhere. The block only issues one-byte read requests and consumes the responses. After reset it reads a two-byte signature. If the signature is correct, it reads the descriptor override fields and the chip-setting fields and holds them for the rest of the chip. If the signature is wrong, or the memory is absent and reads back as all ones, it keeps built-in default values, which are set by parameters.

Once loading is finished, the block answers string requests by index, one at a time. It walks a chain of length-prefixed entries that starts at byte 16. Each entry's first byte is the entry length, so the next entry starts that many bytes further on. A zero length ends the chain. The selected entry is streamed out byte by byte, starting with its length byte, with a valid strobe and a last strobe. A done strobe marks the end of every request, including a request that yields no bytes.

Top module: `cfg_rom_parser`

## Requirements
- R1: `busy` is 1 from reset until loading ends, then stays 0 until the next reset; `str_ready` is 0 while `busy` is 1.
- R2: The signature is the 16-bit value 0x067B, stored little-endian: byte 0 holds 0x7B and byte 1 holds 0x06. `cfg_valid` is 1 after loading exactly when both bytes match.
- R3: When the signature matches, the fields are taken little-endian (low byte at the lower address) from these locations: `vendor_id` from bytes 2..3, `product_id` from 4..5, `release_num` from 6..7, `cfg_attr` from byte 8, `max_power` from byte 9, `op_settings` from byte 10, `fw_ctrl` from 11..13 and `gpio_cfg` from 250..253.
- R4: When the signature does not match, every field output equals its parameter default and every string request yields zero bytes.
- R5: The table starts at byte 16. Each entry holds a length byte L, a type byte and L-2 text bytes. Entry k is found by skipping k entries in order. A request for index k streams the L bytes of entry k, length byte first, with `str_valid` high on each byte. `str_last` and `str_done` are high together with the final byte.
- R6: A length byte of 0 ends the table. A request for an index at or beyond that entry pulses `str_done` with no `str_valid`.
- R7: The walk never reads at or beyond byte 250. An entry whose end would pass byte 250, or an entry that would start at byte 250 or later, counts as the end of the table and yields zero bytes.
- R8: A `str_req` is accepted only in a cycle where `str_ready` is 1. A request raised while loading is dropped and produces no stream and no `str_done`. Requests are served one at a time, in the order they are accepted.
- R9: After loading, the field outputs do not change while string requests are being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | One-cycle read request to the memory |
| mem_addr | output | 8 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data is valid this cycle |
| mem_rsp_data | input | 8 | Read data byte |
| busy | output | 1 | Loading in progress |
| cfg_valid | output | 1 | Signature matched |
| vendor_id | output | 16 | Vendor identifier field |
| product_id | output | 16 | Product identifier field |
| release_num | output | 16 | Device release number field |
| cfg_attr | output | 8 | Configuration attribute byte |
| max_power | output | 8 | Maximum power byte |
| op_settings | output | 8 | Chip operation settings |
| fw_ctrl | output | 24 | External firmware control bytes |
| gpio_cfg | output | 32 | Pin function settings |
| str_req | input | 1 | String request strobe |
| str_idx | input | 3 | Requested string index |
| str_ready | output | 1 | Block can accept a string request |
| str_valid | output | 1 | `str_data` carries a string byte |
| str_data | output | 8 | String byte |
| str_last | output | 1 | Final byte of the entry |
| str_done | output | 1 | Request complete |

## Verification
A wrong signature decision shows up at the ports as soon as `busy` falls. Every field either equals its default or equals the stored bytes, and a matching image that still produces defaults, or a broken one that produces stored values, differs on the first field that is read. A wrong walk pointer or index count shows up in the first string request: the stream has the wrong length byte, bytes belonging to a neighbouring entry, or a misplaced `str_last`. A guard that fails to stop at the upper area either streams bytes where zero bytes are expected or makes a read at address 250 or above.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 8;
  localparam int unsigned IDXW = 3;

  localparam logic [15:0]   SIG_WORD   = 16'h067B;
  localparam logic [AW-1:0] A_SIG_LO   = 8'd0;
  localparam logic [AW-1:0] A_SIG_HI   = 8'd1;
  localparam logic [AW-1:0] A_HEAD_END = 8'd13;
  localparam logic [AW-1:0] A_GPIO_LO  = 8'd250;
  localparam logic [AW-1:0] A_GPIO_HI  = 8'd253;
  localparam logic [AW-1:0] TABLE_BASE = 8'd16;
  localparam logic [AW:0]   GUARD      = 9'd250;

  typedef enum logic [1:0] {LD_REQ, LD_WAIT, LD_DONE} ld_state_e;
  typedef enum logic [2:0] {WK_IDLE, WK_LREQ, WK_LWAIT, WK_DREQ, WK_DWAIT} wk_state_e;

  typedef struct packed {
    logic [15:0] vendor;
    logic [15:0] product;
    logic [15:0] release_n;
    logic [7:0]  attr;
    logic [7:0]  power;
    logic [7:0]  ops;
    logic [23:0] fw;
    logic [31:0] gpio;
  } cfg_fields_t;
endpackage

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgrom_pkg::*;
#(
  parameter cfg_fields_t DEFAULTS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          ld_req,
  output logic [AW-1:0] ld_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          sig_ok,
  output cfg_fields_t   fields
);
  ld_state_e     state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] lo_q;
  logic          ok_q, ok_d;
  logic          wr_en, lo_en;
  cfg_fields_t   fields_q, fields_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    ok_d    = ok_q;
    wr_en   = 1'b0;
    lo_en   = 1'b0;
    unique case (state_q)
      LD_REQ:  state_d = LD_WAIT;
      LD_WAIT: if (rsp_valid) begin
        if (addr_q == A_SIG_LO) begin
          lo_en   = 1'b1;
          addr_d  = A_SIG_HI;
          state_d = LD_REQ;
        end else if (addr_q == A_SIG_HI) begin
          if ({rsp_data, lo_q} == SIG_WORD) begin
            ok_d    = 1'b1;
            addr_d  = addr_q + 8'd1;
            state_d = LD_REQ;
          end else begin
            state_d = LD_DONE;
          end
        end else begin
          wr_en = 1'b1;
          if (addr_q == A_HEAD_END) begin
            addr_d  = A_GPIO_LO;
            state_d = LD_REQ;
          end else if (addr_q == A_GPIO_HI) begin
            state_d = LD_DONE;
          end else begin
            addr_d  = addr_q + 8'd1;
            state_d = LD_REQ;
          end
        end
      end
      default: state_d = LD_DONE;
    endcase
  end

  always_comb begin
    fields_d = fields_q;
    unique case (addr_q)
      8'd2:    fields_d.vendor[7:0]     = rsp_data;
      8'd3:    fields_d.vendor[15:8]    = rsp_data;
      8'd4:    fields_d.product[7:0]    = rsp_data;
      8'd5:    fields_d.product[15:8]   = rsp_data;
      8'd6:    fields_d.release_n[7:0]  = rsp_data;
      8'd7:    fields_d.release_n[15:8] = rsp_data;
      8'd8:    fields_d.attr            = rsp_data;
      8'd9:    fields_d.power           = rsp_data;
      8'd10:   fields_d.ops             = rsp_data;
      8'd11:   fields_d.fw[7:0]         = rsp_data;
      8'd12:   fields_d.fw[15:8]        = rsp_data;
      8'd13:   fields_d.fw[23:16]       = rsp_data;
      8'd250:  fields_d.gpio[7:0]       = rsp_data;
      8'd251:  fields_d.gpio[15:8]      = rsp_data;
      8'd252:  fields_d.gpio[23:16]     = rsp_data;
      8'd253:  fields_d.gpio[31:24]     = rsp_data;
      default: fields_d = fields_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LD_REQ;
      addr_q   <= A_SIG_LO;
      ok_q     <= 1'b0;
      lo_q     <= '0;
      fields_q <= DEFAULTS;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      ok_q    <= ok_d;
      if (lo_en) lo_q <= rsp_data;
      if (wr_en) fields_q <= fields_d;
    end
  end

  assign ld_req  = (state_q == LD_REQ);
  assign ld_addr = addr_q;
  assign busy    = (state_q != LD_DONE);
  assign sig_ok  = ok_q;
  assign fields  = fields_q;

  p_busy_stays_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
  p_fields_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(fields_q));
  p_defaults_on_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ok_q) |-> (fields_q == DEFAULTS));
endmodule

// File: rtl/str_walker.sv
module str_walker
  import cfgrom_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cfg_ok,
  input  logic            str_req,
  input  logic [IDXW-1:0] str_idx,
  output logic            wk_req,
  output logic [AW-1:0]   wk_addr,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            str_ready,
  output logic            str_valid,
  output logic [DW-1:0]   str_data,
  output logic            str_last,
  output logic            str_done
);
  wk_state_e       state_q, state_d;
  logic [AW:0]     ptr_q, ptr_d, end_w;
  logic [IDXW-1:0] tgt_q, tgt_d, cur_q, cur_d;
  logic [DW-1:0]   len_q, len_d, k_q, k_d;
  logic            valid_q, valid_d, last_q, last_d, done_q, done_d;
  logic [DW-1:0]   data_q, data_d;

  assign end_w     = ptr_q + {1'b0, rsp_data};
  assign str_ready = en && (state_q == WK_IDLE);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    tgt_d   = tgt_q;
    cur_d   = cur_q;
    len_d   = len_q;
    k_d     = k_q;
    valid_d = 1'b0;
    last_d  = 1'b0;
    done_d  = 1'b0;
    data_d  = data_q;
    wk_req  = 1'b0;
    wk_addr = ptr_q[AW-1:0];
    unique case (state_q)
      WK_IDLE: if (str_req && str_ready) begin
        if (!cfg_ok) begin
          done_d = 1'b1;
        end else begin
          tgt_d   = str_idx;
          cur_d   = '0;
          ptr_d   = {1'b0, TABLE_BASE};
          state_d = WK_LREQ;
        end
      end
      WK_LREQ: begin
        wk_req  = 1'b1;
        state_d = WK_LWAIT;
      end
      WK_LWAIT: if (rsp_valid) begin
        if (rsp_data == '0 || end_w > GUARD) begin
          done_d  = 1'b1;
          state_d = WK_IDLE;
        end else if (cur_q == tgt_q) begin
          len_d   = rsp_data;
          valid_d = 1'b1;
          data_d  = rsp_data;
          k_d     = 8'd1;
          if (rsp_data == 8'd1) begin
            last_d  = 1'b1;
            done_d  = 1'b1;
            state_d = WK_IDLE;
          end else begin
            state_d = WK_DREQ;
          end
        end else begin
          ptr_d = end_w;
          cur_d = cur_q + 1'b1;
          if (end_w >= GUARD) begin
            done_d  = 1'b1;
            state_d = WK_IDLE;
          end else begin
            state_d = WK_LREQ;
          end
        end
      end
      WK_DREQ: begin
        wk_req  = 1'b1;
        wk_addr = ptr_q[AW-1:0] + k_q;
        state_d = WK_DWAIT;
      end
      WK_DWAIT: if (rsp_valid) begin
        valid_d = 1'b1;
        data_d  = rsp_data;
        if (k_q == len_q - 8'd1) begin
          last_d  = 1'b1;
          done_d  = 1'b1;
          state_d = WK_IDLE;
        end else begin
          k_d     = k_q + 8'd1;
          state_d = WK_DREQ;
        end
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      ptr_q   <= '0;
      tgt_q   <= '0;
      cur_q   <= '0;
      len_q   <= '0;
      k_q     <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      tgt_q   <= tgt_d;
      cur_q   <= cur_d;
      len_q   <= len_d;
      k_q     <= k_d;
      valid_q <= valid_d;
      last_q  <= last_d;
      done_q  <= done_d;
      data_q  <= data_d;
    end
  end

  assign str_valid = valid_q;
  assign str_data  = data_q;
  assign str_last  = last_q;
  assign str_done  = done_q;

  p_walk_in_table_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wk_req |-> (wk_addr >= TABLE_BASE && {1'b0, wk_addr} < GUARD));
  p_last_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    str_last |-> (str_valid && str_done));
  p_quiet_while_loading_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!str_valid && !str_done));
endmodule

// File: rtl/mem_port_mux.sv
module mem_port_mux
  import cfgrom_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_loader,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic          wk_req,
  input  logic [AW-1:0] wk_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr
);
  assign mem_req  = sel_loader ? ld_req  : wk_req;
  assign mem_addr = sel_loader ? ld_addr : wk_addr;

  p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_loader |-> !wk_req);
endmodule

// File: rtl/cfg_rom_parser.sv
module cfg_rom_parser
  import cfgrom_pkg::*;
#(
  parameter logic [15:0] DEF_VENDOR  = 16'hA5C3,
  parameter logic [15:0] DEF_PRODUCT = 16'h0B17,
  parameter logic [15:0] DEF_RELEASE = 16'h0100,
  parameter logic [7:0]  DEF_ATTR    = 8'hC0,
  parameter logic [7:0]  DEF_POWER   = 8'hFA,
  parameter logic [7:0]  DEF_OPS     = 8'h00,
  parameter logic [23:0] DEF_FW      = 24'h000000,
  parameter logic [31:0] DEF_GPIO    = 32'h00000000
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  output logic            busy,
  output logic            cfg_valid,
  output logic [15:0]     vendor_id,
  output logic [15:0]     product_id,
  output logic [15:0]     release_num,
  output logic [7:0]      cfg_attr,
  output logic [7:0]      max_power,
  output logic [7:0]      op_settings,
  output logic [23:0]     fw_ctrl,
  output logic [31:0]     gpio_cfg,
  input  logic            str_req,
  input  logic [IDXW-1:0] str_idx,
  output logic            str_ready,
  output logic            str_valid,
  output logic [DW-1:0]   str_data,
  output logic            str_last,
  output logic            str_done
);
  localparam cfg_fields_t DEFAULTS = '{vendor: DEF_VENDOR, product: DEF_PRODUCT,
    release_n: DEF_RELEASE, attr: DEF_ATTR, power: DEF_POWER, ops: DEF_OPS,
    fw: DEF_FW, gpio: DEF_GPIO};

  logic          ld_req, wk_req, ld_busy, sig_ok;
  logic [AW-1:0] ld_addr, wk_addr;
  cfg_fields_t   fields;

  cfg_loader #(.DEFAULTS(DEFAULTS)) u_loader (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_addr(ld_addr),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .busy(ld_busy), .sig_ok(sig_ok), .fields(fields));

  str_walker u_walker (
    .clk(clk), .rst_n(rst_n), .en(!ld_busy), .cfg_ok(sig_ok),
    .str_req(str_req), .str_idx(str_idx), .wk_req(wk_req), .wk_addr(wk_addr),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .str_ready(str_ready), .str_valid(str_valid), .str_data(str_data),
    .str_last(str_last), .str_done(str_done));

  mem_port_mux u_mux (
    .clk(clk), .rst_n(rst_n), .sel_loader(ld_busy),
    .ld_req(ld_req), .ld_addr(ld_addr), .wk_req(wk_req), .wk_addr(wk_addr),
    .mem_req(mem_req), .mem_addr(mem_addr));

  assign busy        = ld_busy;
  assign cfg_valid   = sig_ok;
  assign vendor_id   = fields.vendor;
  assign product_id  = fields.product;
  assign release_num = fields.release_n;
  assign cfg_attr    = fields.attr;
  assign max_power   = fields.power;
  assign op_settings = fields.ops;
  assign fw_ctrl     = fields.fw;
  assign gpio_cfg    = fields.gpio;

  p_ready_after_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    str_ready |-> !busy);
endmodule

// File: tb/sim_cfg_rom_parser.sv
module sim_cfg_rom_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        mem_req, mem_rsp_valid, busy, cfg_valid;
  logic [7:0]  mem_addr, mem_rsp_data, cfg_attr, max_power, op_settings, str_data;
  logic [15:0] vendor_id, product_id, release_num;
  logic [23:0] fw_ctrl;
  logic [31:0] gpio_cfg;
  logic        str_req = 1'b0, str_ready, str_valid, str_last, str_done;
  logic [2:0]  str_idx = '0;

  cfg_rom_parser u0 (.*);

  logic [7:0] img [256];
  logic [7:0] got [256];
  int checks = 0, errs = 0, cyc = 0;

  // memory model: response two cycles after the request
  logic [7:0] pend_addr;
  int pend_cnt = 0;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend_cnt != 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= img[pend_addr];
      end
    end
    if (mem_req) begin
      pend_cnt  <= 2;
      pend_addr <= mem_addr;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; errs++;
      $display("FAIL watchdog R1 act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] idx;
    logic [7:0] len;
  } vec_t;
  localparam vec_t VECS [10] = '{
    '{3'd0, 8'd4}, '{3'd1, 8'd8}, '{3'd2, 8'd6}, '{3'd3, 8'd2}, '{3'd4, 8'd10},
    '{3'd5, 8'd0}, '{3'd6, 8'd0}, '{3'd7, 8'd0}, '{3'd2, 8'd6}, '{3'd0, 8'd4}};
  localparam int LENS [5] = '{4, 8, 6, 2, 10};

  task automatic put_entry(input int at, input int len, input int tag);
    img[at] = 8'(len);
    if (len > 1) img[at+1] = 8'h03;
    for (int j = 2; j < len; j++) img[at+j] = 8'(tag * 16 + j);
  endtask

  task automatic build_good();
    int p;
    for (int i = 0; i < 256; i++) img[i] = 8'hEE;
    img[0] = 8'h7B; img[1] = 8'h06;
    img[2] = 8'h34; img[3] = 8'h12; img[4] = 8'h78; img[5] = 8'h56;
    img[6] = 8'h00; img[7] = 8'h02; img[8] = 8'hA0; img[9] = 8'h32;
    img[10] = 8'h5A; img[11] = 8'h11; img[12] = 8'h22; img[13] = 8'h33;
    img[250] = 8'h44; img[251] = 8'h55; img[252] = 8'h66; img[253] = 8'h77;
    p = 16;
    for (int e = 0; e < 5; e++) begin
      put_entry(p, LENS[e], e + 1);
      p += LENS[e];
    end
    img[p] = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_req(input logic [2:0] idx, output int n, output int last_pos,
                         output int last_cnt, output bit done_seen);
    n = 0; last_pos = -1; last_cnt = 0; done_seen = 0;
    while (!str_ready) @(negedge clk);
    str_req = 1'b1; str_idx = idx;
    @(negedge clk);
    str_req = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      if (str_valid) begin
        got[n] = str_data;
        if (str_last) begin last_pos = n; last_cnt++; end
        n++;
      end
      if (str_done) begin done_seen = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic expect_stream(input logic [2:0] idx, input int off, input int len, input string req);
    int n, lp, lc, bad;
    bit dn;
    run_req(idx, n, lp, lc, dn);
    chk(dn, {req, " done"}, dn, 1);
    chk(n == len, {req, " length"}, n, len);
    bad = 0;
    for (int j = 0; j < n && j < len; j++) if (got[j] !== img[off+j]) bad++;
    chk(bad == 0, {req, " bytes"}, bad, 0);
    if (len > 0) chk(lc == 1 && lp == len - 1, {req, " last"}, lp, len - 1);
  endtask

  initial begin
    int n, lp, lc, off;
    bit dn;
    // ---------- phase A: valid image ----------
    build_good();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy === 1'b1 && str_ready === 1'b0, "R1 reset state busy/ready", {busy, str_ready}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: request during loading is dropped
    str_req = 1'b1; str_idx = 3'd1;
    @(negedge clk);
    str_req = 1'b0;
    n = 0;
    while (busy) begin
      if (str_valid || str_done) n++;
      @(negedge clk);
    end
    repeat (10) begin
      if (str_valid || str_done) n++;
      @(negedge clk);
    end
    chk(n == 0, "R8 request during load ignored", n, 0);
    chk(busy === 1'b0 && str_ready === 1'b1, "R1 busy cleared, ready", {busy, str_ready}, 2'b01);
    chk(cfg_valid === 1'b1, "R2 signature match", cfg_valid, 1);
    chk(vendor_id == 16'h1234 && product_id == 16'h5678 && release_num == 16'h0200,
        "R3 id fields", {vendor_id, product_id, release_num}, 48'h123456780200);
    chk(cfg_attr == 8'hA0 && max_power == 8'h32 && op_settings == 8'h5A,
        "R3 byte fields", {cfg_attr, max_power, op_settings}, 24'hA0325A);
    chk(fw_ctrl == 24'h332211 && gpio_cfg == 32'h77665544, "R3 fw/gpio fields",
        {fw_ctrl, gpio_cfg}, 56'h33221177665544);
    // vector table: R5 entries, R6 terminator
    foreach (VECS[v]) begin
      off = 16;
      for (int e = 0; e < int'(VECS[v].idx) && e < 5; e++) off += LENS[e];
      expect_stream(VECS[v].idx, off, int'(VECS[v].len),
                    (VECS[v].len == 0) ? "R6 past terminator" : "R5 entry stream");
    end
    chk(vendor_id == 16'h1234 && gpio_cfg == 32'h77665544, "R9 fields unchanged",
        {vendor_id, gpio_cfg}, 48'h123477665544);

    // ---------- phase B: bad signature ----------
    img[1] = 8'h07;
    do_reset();
    while (busy) @(negedge clk);
    chk(cfg_valid === 1'b0, "R2 signature mismatch", cfg_valid, 0);
    chk(vendor_id == 16'hA5C3 && product_id == 16'h0B17 && release_num == 16'h0100,
        "R4 default ids", {vendor_id, product_id, release_num}, 48'hA5C30B170100);
    chk(cfg_attr == 8'hC0 && max_power == 8'hFA && op_settings == 8'h00 &&
        fw_ctrl == 24'h0 && gpio_cfg == 32'h0, "R4 default bytes",
        {cfg_attr, max_power}, 16'hC0FA);
    run_req(3'd0, n, lp, lc, dn);
    chk(dn && n == 0, "R4 no strings on mismatch", n, 0);

    // ---------- phase C: guard near byte 250 ----------
    build_good();
    put_entry(16, 78, 1); put_entry(94, 78, 2); put_entry(172, 80, 3);
    img[250] = 8'h44; img[251] = 8'h55; img[252] = 8'h66; img[253] = 8'h77;
    do_reset();
    while (busy) @(negedge clk);
    expect_stream(3'd1, 94, 78, "R5 long entry");
    expect_stream(3'd2, 172, 0, "R7 entry overruns guard");
    img[172] = 8'd78;
    expect_stream(3'd2, 172, 78, "R7 entry ends at guard");
    expect_stream(3'd3, 250, 0, "R7 start at guard");
    chk(gpio_cfg == 32'h77665544, "R3 gpio after guard walks", gpio_cfg, 32'h77665544);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule